// File: doc/BRIEF.md
# Lamp Ballast Mode Sequencer

This block is the mode controller of a lamp ballast. It takes digital comparator flags from the analog front end: two supply-level flags with hysteresis, an enable flag, two current-sense levels (the ignition-proof level and the over-current level) and an open-load flag. From these it steps the ballast through four modes: lockout wait, ignition, run, and a latched fault. It produces the half-bridge drive enable, the ignition/run select for the oscillator, a duty-reduction code for the pulse shaper, a burst-disable flag and the level of the burst ramp for the dimming comparator downstream.

A single timer serves as the ignition window and then as the burst ramp. In run it advances by a larger step each cycle. A single delay integrator serves two purposes. It times how long an open load lasts before shutdown. It also acts as a progressive regulator that reduces duty cycle under over-current: the count rises while the fault condition is present and holds when it clears. If the integrator reaches full scale, the block enters the fault mode. Only a supply power-cycle clears that fault.

Top module: `lamp_seq`

## Requirements
- R1: After reset, and in the wait mode while enable is low or the supply-rising flag is low, `driveEn`, `runMode`, `burstOff` and `dutyCut` are all 0.
- R2: With the supply-rising flag and enable both high, the next cycle enters ignition (`driveEn`=1, `runMode`=0) with `rampLevel` at 0 and advancing by 1 per cycle. Ignition lasts exactly 2^RAMP_W cycles (256 by default). If the ignition-proof flag is high at the terminal count, run follows (`runMode`=1).
- R3: If the ignition-proof flag is low at the terminal count, the block enters fault (`driveEn`=0, `runMode`=0).
- R4: In run, `rampLevel` starts at 0 and advances by RUN_STEP (30) per cycle, wrapping modulo 2^RAMP_W.
- R5: In run, while the open-load flag is high, `burstOff` is 1 and the delay integrator advances by one per cycle. Once it holds full scale (63), one more cycle with the flag high causes a fault. Counted from a cleared integrator, that is 64 cycles.
- R6: When the open-load flag falls in run before full scale, the integrator returns to 0 in that cycle.
- R7: In run, while over-current is flagged, the integrator advances by one per cycle. `dutyCut` equals its top DUTY_W bits (the count shifted right by 3 by default). When over-current clears, the count and `dutyCut` hold.
- R8: If over-current is still flagged when the integrator holds full scale (`dutyCut`=7), the block enters fault on the next cycle.
- R9: In fault, the drive is off and `dutyCut` reads 0. The fault persists whatever the enable and supply-rising flags do, until the supply-falling flag is seen. After that, a new start needs the supply-rising flag and enable again.
- R10: In any mode, a high supply-falling flag returns the block to the wait mode on the next cycle and clears the timer and the integrator.
- R11: When the open-load and over-current flags are both high, the open-load handling owns the integrator. When open-load then falls with over-current still high, the count clears first and over-current accumulation restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyAboveOn | input | 1 | Supply above the rising lockout threshold |
| supplyBelowOff | input | 1 | Supply below the falling lockout threshold |
| enableIn | input | 1 | Chip enable flag |
| csIgnite | input | 1 | Current sense above the ignition-proof level |
| csOver | input | 1 | Current sense above the over-current level |
| openLoad | input | 1 | Shutdown sense above its threshold |
| driveEn | output | 1 | Half-bridge gate drive allowed |
| runMode | output | 1 | 1 = run frequency, 0 = ignition frequency |
| dutyCut | output | DUTY_W | Duty-reduction code for the pulse shaper |
| burstOff | output | 1 | Burst dimming suppressed, continuous output |
| rampLevel | output | RAMP_W | Ignition timer / burst ramp level |

## Verification
The main sequence is exercised with several flag patterns:
- An enable held low against a good supply separates the enable gate from the supply gate.
- Ignition ending with and without current proof separates the run and fault exits at the same terminal count.
- An over-current burst, a pause, then a longer burst distinguishes holding from clearing and from overflow.
- A short open-load pulse, compared with one held to full scale, distinguishes clear-on-release from the shutdown timeout.
- Open-load and over-current together, then open-load released alone, shows which of the two owns the shared integrator.
- Supply drops in fault and in run show that only the falling flag releases the latch and that counts restart from zero.

// File: rtl/lamp_seq_pkg.sv
package lamp_seq_pkg;

  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_IGNITE = 2'd1,
    ST_RUN    = 2'd2,
    ST_FAULT  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic rampClr;   // timer back to zero
    logic rampStep;  // ignition rate: +1
    logic rampFast;  // burst rate: +RUN_STEP
    logic dlyClr;    // integrator back to zero
    logic dlyInc;    // integrator +1, saturating
  } seqStrobe_t;

endpackage

// File: rtl/lamp_seq_dp.sv
module lamp_seq_dp
  import lamp_seq_pkg::*;
#(
  parameter int RAMP_W   = 8,
  parameter int RUN_STEP = 30,
  parameter int DLY_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  output logic [RAMP_W-1:0] rampLevel,
  output logic              rampDone,
  output logic [DLY_W-1:0]  dlyLevel,
  output logic              dlyFull
);

  localparam logic [RAMP_W-1:0] RAMP_MAX = {RAMP_W{1'b1}};
  localparam logic [RAMP_W-1:0] FAST_INC = RAMP_W'(RUN_STEP);
  localparam logic [DLY_W-1:0]  DLY_MAX  = {DLY_W{1'b1}};

  logic [RAMP_W-1:0] rampQ;
  logic [DLY_W-1:0]  dlyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampQ <= '0;
    end else if (stb.rampClr) begin
      rampQ <= '0;
    end else if (stb.rampFast) begin
      rampQ <= rampQ + FAST_INC;
    end else if (stb.rampStep) begin
      rampQ <= rampQ + RAMP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyQ <= '0;
    end else if (stb.dlyClr) begin
      dlyQ <= '0;
    end else if (stb.dlyInc && (dlyQ != DLY_MAX)) begin
      dlyQ <= dlyQ + DLY_W'(1);
    end
  end

  assign rampLevel = rampQ;
  assign rampDone  = (rampQ == RAMP_MAX);
  assign dlyLevel  = dlyQ;
  assign dlyFull   = (dlyQ == DLY_MAX);

  // Integrator keeps its value when neither strobe is active (regulation hold)
  assert_dly_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.dlyInc && !stb.dlyClr) |=> $stable(dlyLevel));

  // A clear strobe always lands the timer at zero
  assert_ramp_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.rampClr |=> (rampLevel == '0));

endmodule

// File: rtl/lamp_seq_ctl.sv
module lamp_seq_ctl
  import lamp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyAboveOn,
  input  logic       supplyBelowOff,
  input  logic       enableIn,
  input  logic       csIgnite,
  input  logic       csOver,
  input  logic       openLoad,
  input  logic       rampDone,
  input  logic       dlyFull,
  output seqStrobe_t stb,
  output logic       driveEn,
  output logic       runMode,
  output logic       burstOff
);

  seqState_t stateQ, stateD;
  logic      openPrevQ;

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    if (supplyBelowOff) begin
      stateD      = ST_WAIT;
      stb.rampClr = 1'b1;
      stb.dlyClr  = 1'b1;
    end else begin
      unique case (stateQ)
        ST_WAIT: begin
          stb.rampClr = 1'b1;
          stb.dlyClr  = 1'b1;
          if (supplyAboveOn && enableIn) stateD = ST_IGNITE;
        end
        ST_IGNITE: begin
          if (rampDone) begin
            stateD      = csIgnite ? ST_RUN : ST_FAULT;
            stb.rampClr = 1'b1;
            stb.dlyClr  = 1'b1;
          end else begin
            stb.rampStep = 1'b1;
          end
        end
        ST_RUN: begin
          stb.rampFast = 1'b1;
          if (openLoad) begin
            if (dlyFull) stateD = ST_FAULT;
            else         stb.dlyInc = 1'b1;
          end else if (openPrevQ) begin
            stb.dlyClr = 1'b1;
          end else if (csOver) begin
            if (dlyFull) stateD = ST_FAULT;
            else         stb.dlyInc = 1'b1;
          end
        end
        default: begin
          stateD = ST_FAULT;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_WAIT;
      openPrevQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      openPrevQ <= (stateQ == ST_RUN) && openLoad && !supplyBelowOff;
    end
  end

  assign driveEn  = (stateQ == ST_IGNITE) || (stateQ == ST_RUN);
  assign runMode  = (stateQ == ST_RUN);
  assign burstOff = (stateQ == ST_RUN) && openLoad;

  // Run is only ever entered right after the ignition timer expired
  assert_run_after_timer_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runMode) |-> $past(rampDone));

  // Latched fault stays until the supply-falling flag is seen
  assert_fault_latched_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_FAULT && !supplyBelowOff) |=> (stateQ == ST_FAULT));

  // Supply-falling flag forces the wait mode from anywhere
  assert_uv_wait_R10: assert property (@(posedge clk) disable iff (!rstN)
    supplyBelowOff |=> (stateQ == ST_WAIT && !driveEn));

  // Open load with a full integrator ends in fault
  assert_open_timeout_R5: assert property (@(posedge clk) disable iff (!rstN)
    (runMode && openLoad && dlyFull && !supplyBelowOff) |=> (stateQ == ST_FAULT));

endmodule

// File: rtl/lamp_seq.sv
module lamp_seq
  import lamp_seq_pkg::*;
#(
  parameter int RAMP_W   = 8,
  parameter int RUN_STEP = 30,
  parameter int DLY_W    = 6,
  parameter int DUTY_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyAboveOn,
  input  logic              supplyBelowOff,
  input  logic              enableIn,
  input  logic              csIgnite,
  input  logic              csOver,
  input  logic              openLoad,
  output logic              driveEn,
  output logic              runMode,
  output logic [DUTY_W-1:0] dutyCut,
  output logic              burstOff,
  output logic [RAMP_W-1:0] rampLevel
);

  seqStrobe_t       stb;
  logic             rampDone;
  logic             dlyFull;
  logic [DLY_W-1:0] dlyLevel;

  lamp_seq_ctl u_ctl (
    .clk           (clk),
    .rstN          (rstN),
    .supplyAboveOn (supplyAboveOn),
    .supplyBelowOff(supplyBelowOff),
    .enableIn      (enableIn),
    .csIgnite      (csIgnite),
    .csOver        (csOver),
    .openLoad      (openLoad),
    .rampDone      (rampDone),
    .dlyFull       (dlyFull),
    .stb           (stb),
    .driveEn       (driveEn),
    .runMode       (runMode),
    .burstOff      (burstOff)
  );

  lamp_seq_dp #(
    .RAMP_W  (RAMP_W),
    .RUN_STEP(RUN_STEP),
    .DLY_W   (DLY_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rampLevel(rampLevel),
    .rampDone (rampDone),
    .dlyLevel (dlyLevel),
    .dlyFull  (dlyFull)
  );

  assign dutyCut = runMode ? dlyLevel[DLY_W-1 -: DUTY_W] : '0;

endmodule

// File: tb/lamp_seq_tb.sv
module lamp_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NROW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supHi = 1'b0, supLo = 1'b0, en = 1'b0, ign = 1'b0, oc = 1'b0, sd = 1'b0;
  logic drv, run, boff;
  logic [2:0] duty;
  logic [7:0] ramp;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lamp_seq u_dut (
    .clk(clk), .rstN(rstN),
    .supplyAboveOn(supHi), .supplyBelowOff(supLo), .enableIn(en),
    .csIgnite(ign), .csOver(oc), .openLoad(sd),
    .driveEn(drv), .runMode(run), .dutyCut(duty), .burstOff(boff),
    .rampLevel(ramp)
  );

  // Row: {req[4], stim{supHi,supLo,en,ign,oc,sd}[6], cycles[10], drv, run, boff, duty[3]}
  localparam logic [25:0] VEC [NROW] = '{
    {4'd1, 6'b100000, 10'd3,   1'b0, 1'b0, 1'b0, 3'd0}, // R1 enable low
    {4'd2, 6'b101100, 10'd1,   1'b1, 1'b0, 1'b0, 3'd0}, // R2 ignition entry
    {4'd2, 6'b101100, 10'd255, 1'b1, 1'b0, 1'b0, 3'd0}, // R2 still igniting
    {4'd2, 6'b101100, 10'd1,   1'b1, 1'b1, 1'b0, 3'd0}, // R2 run
    {4'd5, 6'b101101, 10'd10,  1'b1, 1'b1, 1'b1, 3'd1}, // R5 open load counting
    {4'd6, 6'b101100, 10'd1,   1'b1, 1'b1, 1'b0, 3'd0}, // R6 cleared on release
    {4'd7, 6'b101110, 10'd20,  1'b1, 1'b1, 1'b0, 3'd2}, // R7 over-current rise
    {4'd7, 6'b101100, 10'd5,   1'b1, 1'b1, 1'b0, 3'd2}, // R7 hold
    {4'd8, 6'b101110, 10'd43,  1'b1, 1'b1, 1'b0, 3'd7}, // R8 at full scale
    {4'd8, 6'b101110, 10'd1,   1'b0, 1'b0, 1'b0, 3'd0}, // R8 fault
    {4'd9, 6'b100100, 10'd4,   1'b0, 1'b0, 1'b0, 3'd0}, // R9 latched, enable low
    {4'd9, 6'b101100, 10'd4,   1'b0, 1'b0, 1'b0, 3'd0}, // R9 latched, enable high
    {4'd9, 6'b011100, 10'd1,   1'b0, 1'b0, 1'b0, 3'd0}, // R9 supply fell: wait
    {4'd9, 6'b101000, 10'd1,   1'b1, 1'b0, 1'b0, 3'd0}, // R9 restart
    {4'd2, 6'b101000, 10'd255, 1'b1, 1'b0, 1'b0, 3'd0}, // R2 igniting
    {4'd3, 6'b101000, 10'd1,   1'b0, 1'b0, 1'b0, 3'd0}  // R3 no proof: fault
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [5:0] s);
    {supHi, supLo, en, ign, oc, sd} = s;
  endtask

  task automatic toRun();
    drive(6'b011100); tick(1);
    drive(6'b101100); tick(257);
    check("R2", "runMode after restart", run, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(3*CLK_PERIOD + 2);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    check("R1", "driveEn reset", drv, 0);
    check("R1", "runMode reset", run, 0);
    check("R1", "dutyCut reset", duty, 0);
    check("R1", "burstOff reset", boff, 0);

    for (int i = 0; i < NROW; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i][25:22]);
      drive(VEC[i][21:16]);
      tick(int'(VEC[i][15:6]));
      check(tag, $sformatf("row %0d driveEn", i), drv, VEC[i][5]);
      check(tag, $sformatf("row %0d runMode", i), run, VEC[i][4]);
      check(tag, $sformatf("row %0d burstOff", i), boff, VEC[i][3]);
      check(tag, $sformatf("row %0d dutyCut", i), duty, VEC[i][2:0]);
    end

    // R4 burst ramp rate in run
    toRun();
    check("R4", "ramp at run entry", ramp, 0);
    tick(3);
    check("R4", "ramp after 3", ramp, 90);
    tick(6);
    check("R4", "ramp wraps", ramp, 14);

    // R5 open-load timeout: 63 cycles stays up, 64th faults
    drive(6'b101101); tick(63);
    check("R5", "still run at full", run, 1);
    check("R5", "duty at full", duty, 7);
    tick(1);
    check("R5", "fault after timeout", drv, 0);

    // R11 priority of open load over over-current
    toRun();
    drive(6'b101111); tick(8);
    check("R11", "both flags count", duty, 1);
    check("R11", "burstOff with both", boff, 1);
    drive(6'b101110); tick(1);
    check("R11", "clear on open-load release", duty, 0);
    tick(16);
    check("R11", "over-current restarts", duty, 2);

    // R10 supply drop in run clears counts
    drive(6'b011110); tick(1);
    check("R10", "wait after drop", drv, 0);
    check("R10", "runMode after drop", run, 0);
    drive(6'b101100); tick(257);
    check("R10", "run again", run, 1);
    check("R10", "duty cleared", duty, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule